// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block sequences the low-power sleep state of a small processor core and its return to execution. The core runs on a four-phase instruction cycle. Each cycle fetches one word while the previously fetched word executes. A sleep instruction that executes while the external interrupt flag is clear stops the phase generator and the program counter. Execution stays frozen until the interrupt flag is set by a rising edge on the external interrupt pin.

On wake, the crystal oscillator modes hold the core for a start-up interval of 1024 oscillator periods. The RC mode resumes on the next clock. The first cycle after wake executes the word prefetched during the sleep instruction. After that cycle, the global interrupt enable selects the path. With it set, one dummy cycle fetches the interrupt vector while the return address is pushed and the enable is cleared. With it clear, execution simply continues in line. Instruction decoding is outside the block: `sleep_req` tells it that the instruction executing in the current cycle is a sleep.

The controller has five states. ST_RUN is normal execution. ST_DOZE is asleep, waiting for the flag. ST_OSC is the start-up hold. ST_RESUME is the first cycle after wake. ST_VECTOR is the dummy cycle.

The transitions are:
- ST_RUN to ST_DOZE: at the last phase of a cycle, when `sleep_req` is high and the flag is clear.
- ST_DOZE to ST_OSC: when the flag is set in a crystal mode.
- ST_DOZE to ST_RESUME: when the flag is set in RC mode.
- ST_OSC to ST_RESUME: when the start-up count completes.
- ST_RESUME to ST_VECTOR: at the end of the cycle, with the enable set.
- ST_RESUME to ST_RUN: at the end of the cycle, with the enable clear.
- ST_VECTOR to ST_RUN: at the end of the dummy cycle.

Top module: `sws_sleep_wake`

## Requirements
- R1: While running, `q_stb` is one-hot and steps through bit 0 to bit 3 (first to fourth phase) on successive clocks. Each instruction cycle therefore lasts four clocks. `fetch_stb` is high in the first phase of every running cycle, and `pc` (the fetch address) increases by one per cycle.
- R2: When `sleep_req` is high in the fourth phase of a running cycle and `int_flag` is low, the core enters sleep. `pc` advances once more, to the address after the one fetched in that cycle, and then holds. `q_stb`, `fetch_stb` and `exec_stb` stay low for as long as the core sleeps.
- R3: A rising edge on `int_pin` sets `int_flag`, which is visible one clock later. The flag stays set until a clock with `int_clr` high clears it. A rising edge in the same clock as `int_clr` wins, and the flag stays set.
- R4: A set `int_flag` ends sleep.
- R5: `osc_mode` is encoded as 0 = LP, 1 = XT, 2 = HS, 3 = RC. In LP, XT and HS the first `fetch_stb` after wake comes 1025 clocks after `int_flag` is first seen high: one clock to leave sleep, then a hold of 1024 oscillator periods.
- R6: In RC mode (`osc_mode` = 3) there is no hold. The first `fetch_stb` comes one clock after `int_flag` is first seen high.
- R7: The first cycle after wake has `exec_stb` high and fetches the address held during sleep. That cycle executes the instruction prefetched during the sleep cycle.
- R8: With `gie` high, the cycle after the wake cycle is a dummy cycle. It fetches address 4 with `exec_stb` low. In its first phase, `push_vld` and `gie_clr` are high and `push_addr` equals the fetch address of the wake cycle. The following cycle fetches address 5 with `exec_stb` high.
- R9: With `gie` low, the cycle after the wake cycle fetches the next address in line with `exec_stb` high. `push_vld` and `gie_clr` stay low.
- R10: A sleep request in a cycle where `int_flag` is already set has no effect. The next cycle runs normally: `q_stb` bit 0 is set, `fetch_stb` is high and `pc` has advanced by one.
- R11: After reset, the core is running in the first phase with `pc` = 0, `int_flag` low and `push_vld` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Instruction executing in this cycle is a sleep |
| int_pin | input | 1 | External interrupt pin (rising edge sensitive) |
| int_clr | input | 1 | Software clear of the interrupt flag |
| gie | input | 1 | Global interrupt enable |
| osc_mode | input | 2 | 0 LP, 1 XT, 2 HS, 3 RC |
| q_stb | output | 4 | One-hot phase strobes, all low while asleep |
| pc | output | PC_W | Fetch address of the current cycle |
| fetch_stb | output | 1 | Fetch in this cycle (first phase) |
| exec_stb | output | 1 | Real execute in this cycle (first phase) |
| push_vld | output | 1 | Return address push on vectoring |
| push_addr | output | PC_W | Return address |
| gie_clr | output | 1 | Clear request for the global enable |
| int_flag | output | 1 | External interrupt flag |

## Verification
The sleep and wake path is swept over every oscillator mode crossed with both enable values. The crystal modes show the 1025-clock wake latency and the RC mode shows a one-clock latency, so a missing or misapplied hold is exposed by each mode. Enable high and enable low tell vectoring apart from in-line continuation: the bench checks the dummy cycle's vector fetch, the pushed return address and the suppressed execute against in-line addresses. Separate patterns cover a sleep request with the flag already set, an edge coinciding with a clear, and the phase and address stepping out of reset.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_DOZE,
        ST_OSC,
        ST_RESUME,
        ST_VECTOR
    } sws_state_t;

    localparam logic [1:0] OSC_LP = 2'd0;
    localparam logic [1:0] OSC_XT = 2'd1;
    localparam logic [1:0] OSC_HS = 2'd2;
    localparam logic [1:0] OSC_RC = 2'd3;

endpackage

// File: rtl/sws_qphase.sv
module sws_qphase #(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [PHASES-1:0] q_stb,
    output logic              last_q
);
    localparam int QW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [QW-1:0] QLAST = QW'(PHASES - 1);

    logic [QW-1:0] qcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt <= '0;
        end else if (advance) begin
            qcnt <= (qcnt == QLAST) ? '0 : qcnt + 1'b1;
        end
    end

    always_comb begin
        q_stb = '0;
        if (advance) begin
            q_stb[qcnt] = 1'b1;
        end
        last_q = advance && (qcnt == QLAST);
    end

    a_r1_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_stb));

    a_r1_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (last_q && advance) |=> (qcnt == '0));

endmodule

// File: rtl/sws_ost_timer.sv
module sws_ost_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT) + 1;
    localparam logic [CW-1:0] CLAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == CLAST);

    a_r5_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done && !load) |=> (cnt == $past(cnt) + 1'b1));

    a_r5_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == '0));

endmodule

// File: rtl/sws_int_flag.sv
module sws_int_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic flag
);
    logic pin_d;
    logic rise;

    assign rise = pin && !pin_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_d <= 1'b0;
            flag  <= 1'b0;
        end else begin
            pin_d <= pin;
            if (rise) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> flag);

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !flag);

endmodule

// File: rtl/sws_sleep_wake.sv
module sws_sleep_wake
    import sws_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int OST_PERIODS = 1024,
    parameter int INT_VEC     = 4,
    parameter int RESET_PC    = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic            int_pin,
    input  logic            int_clr,
    input  logic            gie,
    input  logic [1:0]      osc_mode,
    output logic [3:0]      q_stb,
    output logic [PC_W-1:0] pc,
    output logic            fetch_stb,
    output logic            exec_stb,
    output logic            push_vld,
    output logic [PC_W-1:0] push_addr,
    output logic            gie_clr,
    output logic            int_flag
);
    localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(INT_VEC);
    localparam logic [PC_W-1:0] RST_ADDR = PC_W'(RESET_PC);

    sws_state_t      state_q;
    sws_state_t      state_d;
    logic            active;
    logic            asleep;
    logic            last_q;
    logic            crystal;
    logic            sleep_go;
    logic            ost_done;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] ret_q;

    assign active   = (state_q == ST_RUN) || (state_q == ST_RESUME) || (state_q == ST_VECTOR);
    assign asleep   = (state_q == ST_DOZE) || (state_q == ST_OSC);
    assign crystal  = (osc_mode != OSC_RC);
    assign sleep_go = (state_q == ST_RUN) && last_q && sleep_req && !int_flag;

    sws_qphase #(.PHASES(4)) i_qphase (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (active),
        .q_stb   (q_stb),
        .last_q  (last_q)
    );

    sws_ost_timer #(.LIMIT(OST_PERIODS)) i_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sleep_go),
        .run   (state_q == ST_OSC),
        .done  (ost_done)
    );

    sws_int_flag i_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (int_pin),
        .clr   (int_clr),
        .flag  (int_flag)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_go) state_d = ST_DOZE;
            end
            ST_DOZE: begin
                if (int_flag) state_d = crystal ? ST_OSC : ST_RESUME;
            end
            ST_OSC: begin
                if (ost_done) state_d = ST_RESUME;
            end
            ST_RESUME: begin
                if (last_q) state_d = gie ? ST_VECTOR : ST_RUN;
            end
            ST_VECTOR: begin
                if (last_q) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // program counter and return address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= RST_ADDR;
            ret_q <= '0;
        end else if (active && last_q) begin
            if (state_q == ST_RESUME) begin
                ret_q <= pc_q;
                pc_q  <= gie ? VEC_ADDR : pc_q + 1'b1;
            end else begin
                pc_q  <= pc_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pc        = pc_q;
        push_addr = ret_q;
        fetch_stb = active && q_stb[0];
        exec_stb  = active && q_stb[0] && (state_q != ST_VECTOR);
        push_vld  = (state_q == ST_VECTOR) && q_stb[0];
        gie_clr   = (state_q == ST_VECTOR) && q_stb[0];
    end

    a_r2_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (q_stb == '0 && !fetch_stb && !exec_stb));

    a_r2_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && $past(asleep)) |-> $stable(pc_q));

    a_r4_stays_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOZE && !int_flag) |=> (state_q == ST_DOZE));

    a_r6_rc_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOZE && int_flag && osc_mode == OSC_RC) |=> (state_q == ST_RESUME));

    a_r5_hold_crystal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOZE && int_flag && osc_mode != OSC_RC) |=> (state_q == ST_OSC));

    a_r8_push_at_vector: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld |-> (pc_q == VEC_ADDR && !exec_stb && gie_clr));

    a_r10_noop_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && last_q && sleep_req && int_flag) |=> (state_q == ST_RUN));

endmodule

// File: tb/test_sws_sleep_wake.sv
`timescale 1ns/1ps
module test_sws_sleep_wake;
    localparam int PC_W = 13;
    localparam int OST  = 1024;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_req = 1'b0;
    logic            int_pin = 1'b0;
    logic            int_clr = 1'b0;
    logic            gie = 1'b0;
    logic [1:0]      osc_mode = 2'd0;
    logic [3:0]      q_stb;
    logic [PC_W-1:0] pc;
    logic            fetch_stb;
    logic            exec_stb;
    logic            push_vld;
    logic [PC_W-1:0] push_addr;
    logic            gie_clr;
    logic            int_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sws_sleep_wake #(.PC_W(PC_W), .OST_PERIODS(OST)) i_sws_sleep_wake (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .int_pin(int_pin),
        .int_clr(int_clr), .gie(gie), .osc_mode(osc_mode), .q_stb(q_stb),
        .pc(pc), .fetch_stb(fetch_stb), .exec_stb(exec_stb), .push_vld(push_vld),
        .push_addr(push_addr), .gie_clr(gie_clr), .int_flag(int_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic to_q1();
        do @(negedge clk); while (!q_stb[0]);
    endtask

    task automatic clear_flag();
        @(negedge clk) int_clr = 1'b1;
        @(negedge clk) int_clr = 1'b0;
        chk("R3 flag cleared", 32'(int_flag), 0);
    endtask

    task automatic sleep_wake(input logic [1:0] mode, input logic g);
        logic [PC_W-1:0] s;
        int n;
        osc_mode = mode;
        gie = g;
        to_q1();
        s = pc;
        sleep_req = 1'b1;
        repeat (3) @(negedge clk);
        @(negedge clk) sleep_req = 1'b0;
        chk("R2 strobes off", 32'(q_stb), 0);
        chk("R2 pc after sleep", 32'(pc), 32'(s + 1'b1));
        repeat (20) @(negedge clk);
        chk("R2 still quiet", 32'({q_stb, fetch_stb, exec_stb}), 0);
        chk("R2 pc frozen", 32'(pc), 32'(s + 1'b1));
        int_pin = 1'b1;
        @(negedge clk);
        chk("R3 flag set", 32'(int_flag), 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!fetch_stb && n < 5000);
        chk((mode == 2'd3) ? "R6 rc wake latency" : "R5 crystal wake latency",
            n, (mode == 2'd3) ? 1 : OST + 1);
        int_pin = 1'b0;
        chk("R7 wake fetch addr", 32'(pc), 32'(s + 1'b1));
        chk("R7 wake executes", 32'(exec_stb), 1);
        chk("R4 phase restarts", 32'(q_stb), 1);
        repeat (4) @(negedge clk);
        if (g) begin
            chk("R8 vector fetch", 32'(pc), 4);
            chk("R8 dummy no exec", 32'({fetch_stb, exec_stb}), 2);
            chk("R8 push", 32'({push_vld, gie_clr}), 3);
            chk("R8 return addr", 32'(push_addr), 32'(s + 1'b1));
            repeat (4) @(negedge clk);
            chk("R8 next fetch", 32'(pc), 5);
            chk("R8 exec resumes", 32'(exec_stb), 1);
        end else begin
            chk("R9 in-line fetch", 32'(pc), 32'(s + 2'd2));
            chk("R9 exec", 32'(exec_stb), 1);
            chk("R9 no push", 32'({push_vld, gie_clr}), 0);
        end
        chk("R3 flag sticky", 32'(int_flag), 1);
        clear_flag();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 reset pc", 32'(pc), 0);
        chk("R11 reset phase", 32'(q_stb), 1);
        chk("R11 reset flag", 32'(int_flag), 0);
        chk("R11 reset push", 32'(push_vld), 0);

        to_q1();
        begin
            logic [PC_W-1:0] base;
            base = pc;
            for (int i = 0; i < 12; i++) begin
                chk("R1 phase", 32'(q_stb), 32'(1 << (i % 4)));
                chk("R1 pc step", 32'(pc), 32'(base + PC_W'(i / 4)));
                chk("R1 fetch strobe", 32'(fetch_stb), (i % 4 == 0) ? 1 : 0);
                @(negedge clk);
            end
        end

        for (int m = 0; m < 4; m++) begin
            for (int g = 0; g < 2; g++) begin
                sleep_wake(2'(m), g[0]);
            end
        end

        // R10: flag already set, sleep is a no-op
        to_q1();
        int_pin = 1'b1;
        @(negedge clk) int_pin = 1'b0;
        to_q1();
        begin
            logic [PC_W-1:0] s;
            s = pc;
            sleep_req = 1'b1;
            repeat (3) @(negedge clk);
            @(negedge clk) sleep_req = 1'b0;
            chk("R10 phase runs", 32'(q_stb), 1);
            chk("R10 fetch", 32'(fetch_stb), 1);
            chk("R10 pc", 32'(pc), 32'(s + 1'b1));
        end
        clear_flag();

        // R3: edge in same clock as clear wins
        @(negedge clk) begin
            int_pin = 1'b1;
            int_clr = 1'b1;
        end
        @(negedge clk) begin
            int_pin = 1'b0;
            int_clr = 1'b0;
        end
        chk("R3 edge beats clear", 32'(int_flag), 1);
        clear_flag();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule